// File: doc/BRIEF.md
# Per-Lane Bidirectional Variable Shifter

This block splits a 128-bit data vector into equal lanes and shifts every lane by an amount taken from the matching lane of a second 128-bit count vector. Only the low byte of each count lane matters. That byte is read as a two's-complement number. A zero or positive value shifts the lane left, and a negative value shifts it right by its magnitude.

The lane width is 8, 16, 32 or 64 bits, chosen by a 2-bit size code. A mode input selects signed or unsigned data, and this decides how right shifts fill the lane and what an oversized count produces.

A result is captured into an output register on every cycle where the input is flagged valid. It appears, with its own valid flag, one clock later. No value ever moves from one lane into another.

Top module: `vec_var_shift`

## Requirements
- R1: The count of each lane is bits [7:0] of that lane of `count_in`, read as signed (-128..127); all higher bits of the count lane are ignored.
- R2: `size_sel` selects the lane width: 0 = 8 bits (16 lanes), 1 = 16 bits (8 lanes), 2 = 32 bits (4 lanes), 3 = 64 bits (2 lanes); lane i occupies bits [i*W +: W] of both vectors.
- R3: A count in 0..W-1 shifts the lane left by the count, filling with zeros; bits moved past the lane's top are lost, with no saturation.
- R4: With `signed_mode` = 0, a count in -(W-1)..-1 gives a logical right shift by the magnitude (zero fill).
- R5: With `signed_mode` = 1, a count in -(W-1)..-1 gives an arithmetic right shift by the magnitude (the lane's top bit is copied in).
- R6: With `signed_mode` = 0, a count whose magnitude is W or more, in either direction, gives an all-zero lane.
- R7: With `signed_mode` = 1, a count of W or more gives an all-zero lane.
- R8: With `signed_mode` = 1, a count of -W or less gives all ones if the lane's top bit is 1, and all zeros otherwise.
- R9: Each lane result depends only on its own data lane and count lane; different counts in neighbouring lanes never disturb each other.
- R10: `out_valid` is high exactly one cycle after an accepted `in_valid`. `data_out` takes the new result on that cycle and keeps its value while `in_valid` is low.
- R11: While `rst_n` is low at a clock edge, `out_valid` and `data_out` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accepts the present inputs this cycle |
| size_sel | input | 2 | Lane width code (R2) |
| signed_mode | input | 1 | 1 = signed data, 0 = unsigned |
| data_in | input | 128 | Vector of lanes to shift |
| count_in | input | 128 | Vector of per-lane signed counts |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| data_out | output | 128 | Registered shifted vector |

## Verification
The assertions assume that `in_valid`, `size_sel`, `signed_mode` and both vectors are steady at each rising edge, and that `in_valid` stays low while reset is held. The bench drives every input on the falling edge and keeps `in_valid` low through reset, so both assumptions hold.

The lane-level assertions only watch the lowest lane at one width each. The bench therefore sweeps every size code with random data and with counts spread over the full byte range, and adds garbage in the upper count bits. This reaches the in-range, boundary and oversized cases in both modes.

// File: rtl/vshift_pkg.sv
// Package: shared widths and the lane-size code for the per-lane shifter.
// Assumes lane widths are powers of two starting at MIN_LANE_W.
package vshift_pkg;
    localparam int VEC_W      = 128;
    localparam int CNT_W      = 8;
    localparam int MIN_LANE_W = 8;
    localparam int NUM_SIZES  = 4;
    localparam int SIZE_W     = $clog2(NUM_SIZES);

    typedef enum logic [SIZE_W-1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_size_e;
endpackage

// File: rtl/vshift_lane.sv
// Module: one lane of the variable shifter, purely combinational.
// Reads a signed CNT_W-bit count. Non-negative counts shift left, negative
// ones shift right. Oversized counts give zero or sign fill, as the mode says.
// Assumes LANE_W >= CNT_W so the count always fits inside the lane.
module vshift_lane #(
    parameter int LANE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic [LANE_W-1:0] lane_d,
    input  logic [CNT_W-1:0]  lane_cnt,
    input  logic              is_signed,
    output logic [LANE_W-1:0] lane_q
);
    localparam int MAG_W = CNT_W + 1;
    localparam logic [MAG_W-1:0] WIDTH_LIM = MAG_W'(LANE_W);

    logic             go_right;
    logic [MAG_W-1:0] magnitude;
    logic             over_range;
    logic             sign_bit;
    logic [LANE_W-1:0] left_res;
    logic [LANE_W-1:0] right_res;

    // Split the signed count into a direction and a magnitude.
    always_comb begin
        go_right   = lane_cnt[CNT_W-1];
        magnitude  = go_right ? (~{1'b1, lane_cnt} + MAG_W'(1)) : {1'b0, lane_cnt};
        over_range = (magnitude >= WIDTH_LIM);
        sign_bit   = is_signed & lane_d[LANE_W-1];
    end

    // Form the in-range shifted values for both directions.
    always_comb begin
        left_res = lane_d << magnitude;
        if (is_signed) begin
            right_res = LANE_W'($signed(lane_d) >>> magnitude);
        end else begin
            right_res = lane_d >> magnitude;
        end
    end

    // Pick the final lane value, including the oversized-count cases.
    always_comb begin
        if (!go_right) begin
            lane_q = over_range ? '0 : left_res;
        end else if (over_range) begin
            lane_q = sign_bit ? '1 : '0;
        end else begin
            lane_q = right_res;
        end
    end
endmodule

// File: rtl/vshift_group.sv
// Module: every lane of the vector for one fixed lane width.
// Repeats vshift_lane VEC_W/LANE_W times. Each lane takes its count from the
// low CNT_W bits of the matching count lane.
// Assumes VEC_W is a multiple of LANE_W.
module vshift_group #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic [VEC_W-1:0] vec_d,
    input  logic [VEC_W-1:0] vec_cnt,
    input  logic             is_signed,
    output logic [VEC_W-1:0] vec_q
);
    localparam int N_LANES = VEC_W / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        vshift_lane #(
            .LANE_W (LANE_W),
            .CNT_W  (CNT_W)
        ) u_lane (
            .lane_d    (vec_d[i*LANE_W +: LANE_W]),
            .lane_cnt  (vec_cnt[i*LANE_W +: CNT_W]),
            .is_signed (is_signed),
            .lane_q    (vec_q[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/vec_var_shift.sv
// Module: top of the per-lane bidirectional shifter.
// Builds one lane group for each supported width, selects a group with the
// size code and registers the result with a valid flag.
// Assumes inputs are stable at the clock edge. Reset is synchronous and active low.
module vec_var_shift
    import vshift_pkg::*;
#(
    parameter int VEC_W = vshift_pkg::VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              signed_mode,
    input  logic [VEC_W-1:0]  data_in,
    input  logic [VEC_W-1:0]  count_in,
    output logic              out_valid,
    output logic [VEC_W-1:0]  data_out
);
    logic [VEC_W-1:0] group_q [NUM_SIZES];
    logic [VEC_W-1:0] chosen;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
        vshift_group #(
            .VEC_W  (VEC_W),
            .LANE_W (MIN_LANE_W << g),
            .CNT_W  (CNT_W)
        ) u_group (
            .vec_d     (data_in),
            .vec_cnt   (count_in),
            .is_signed (signed_mode),
            .vec_q     (group_q[g])
        );
    end

    // Select the lane group that matches the size code.
    always_comb begin
        chosen = group_q[size_sel];
    end

    // Register the result and its valid flag; the data holds while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            data_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                data_out <= chosen;
            end
        end
    end
endmodule

// File: rtl/vec_var_shift_chk.sv
// Checker: timing and lane-0 corner properties of vec_var_shift.
// Assumes inputs are stable at rising edges.
module vec_var_shift_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       size_sel,
    input logic             signed_mode,
    input logic [VEC_W-1:0] data_in,
    input logic [VEC_W-1:0] count_in,
    input logic             out_valid,
    input logic [VEC_W-1:0] data_out
);
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && data_out == '0));

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(data_out)));

    assert_zero_count_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_sel == 2'd3 && count_in[7:0] == 8'd0)
        |=> data_out[63:0] == $past(data_in[63:0]));

    assert_unsigned_far_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !signed_mode && size_sel == 2'd0 && !count_in[7] && count_in[6:3] != 4'd0)
        |=> data_out[7:0] == 8'd0);

    assert_signed_far_right_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && signed_mode && size_sel == 2'd0 && $signed(count_in[7:0]) <= -8)
        |=> data_out[7:0] == {8{$past(data_in[7])}});
endmodule

bind vec_var_shift vec_var_shift_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .size_sel    (size_sel),
    .signed_mode (signed_mode),
    .data_in     (data_in),
    .count_in    (count_in),
    .out_valid   (out_valid),
    .data_out    (data_out)
);

// File: tb/tb_vec_var_shift.sv
`timescale 1ns/1ps
module tb_vec_var_shift;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   size_sel = 2'd0;
    logic         signed_mode = 1'b0;
    logic [127:0] data_in = '0;
    logic [127:0] count_in = '0;
    logic         out_valid;
    logic [127:0] data_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vec_var_shift dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
        .signed_mode(signed_mode), .data_in(data_in), .count_in(count_in),
        .out_valid(out_valid), .data_out(data_out)
    );

    // Expected vector, worked out from the requirements lane by lane.
    function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] c,
                                           input logic [1:0] sz, input logic sg);
        int w, n, k, m;
        logic [63:0] mask, x, xs, r;
        logic [7:0] cb;
        logic [127:0] res;
        w = 8 << sz;
        n = 128 / w;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        res = '0;
        for (int i = 0; i < n; i++) begin
            x  = 64'(d >> (i * w)) & mask;
            cb = 8'(c >> (i * w));
            k  = int'($signed(cb));
            if (k >= 0) begin
                r = (k >= w) ? 64'd0 : ((x << k) & mask);
            end else begin
                m = -k;
                if (sg) begin
                    xs = x[w-1] ? (x | ~mask) : x;
                    if (m >= w) r = x[w-1] ? mask : 64'd0;
                    else        r = 64'($signed(xs) >>> m) & mask;
                end else begin
                    r = (m >= w) ? 64'd0 : (x >> m);
                end
            end
            res |= (128'(r) << (i * w));
        end
        return res;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one vector, then check it on the falling edge after it is registered.
    task automatic run(input logic [127:0] d, input logic [127:0] c,
                       input logic [1:0] sz, input logic sg, input string req);
        logic [127:0] exp;
        exp = model(d, c, sz, sg);
        @(negedge clk);
        data_in = d; count_in = c; size_sel = sz; signed_mode = sg; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R10 valid", {127'd0, out_valid}, 128'd1);
        check(data_out === exp, req, data_out, exp);
    endtask

    // Fill every lane of width 8<<sz with one byte count, upper bits given.
    function automatic logic [127:0] spread(input logic [7:0] cnt, input logic [1:0] sz,
                                            input logic [55:0] upper);
        int w;
        logic [127:0] v;
        logic [63:0] lane;
        w = 8 << sz;
        v = '0;
        lane = {upper, cnt};
        if (w < 64) lane = lane & ((64'd1 << w) - 64'd1);
        for (int i = 0; i < 128 / w; i++) v |= (128'(lane) << (i * w));
        return v;
    endfunction

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] d, c, held;
        int seed_probe;
        seed_probe = $urandom(32'h5eed1234);
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && data_out === '0, "R11 reset", data_out, '0);
        rst_n = 1'b1;

        // Directed counts at the boundaries for every width and mode.
        for (int sz = 0; sz < 4; sz++) begin
            for (int sg = 0; sg < 2; sg++) begin
                int w;
                w = 8 << sz;
                d = {4{32'h8123_4F7E}};
                run(d, spread(8'd0, 2'(sz), 56'd0), 2'(sz), 1'(sg), "R3 zero count");
                run(d, spread(8'(w - 1), 2'(sz), 56'd0), 2'(sz), 1'(sg), "R3 left max");
                run(d, spread(8'(w), 2'(sz), 56'd0), 2'(sz), 1'(sg), sg ? "R7 left W" : "R6 left W");
                run(d, spread(8'd127, 2'(sz), 56'd0), 2'(sz), 1'(sg), sg ? "R7 left 127" : "R6 left 127");
                run(d, spread(8'hFF, 2'(sz), 56'd0), 2'(sz), 1'(sg), sg ? "R5 right 1" : "R4 right 1");
                run(d, spread(8'(-(w - 1)), 2'(sz), 56'd0), 2'(sz), 1'(sg), sg ? "R5 right max" : "R4 right max");
                run(d, spread(8'(-w), 2'(sz), 56'd0), 2'(sz), 1'(sg), sg ? "R8 right W" : "R6 right W");
                run(~d, spread(8'h80, 2'(sz), 56'd0), 2'(sz), 1'(sg), sg ? "R8 right 128" : "R6 right 128");
                run(d, spread(8'd3, 2'(sz), 56'hA5_5A5A_A5A5_5A5A), 2'(sz), 1'(sg), "R1 upper ignored");
            end
        end

        // R2/R9: different counts in each lane at all widths.
        run({8{16'h8001}}, 128'h0105_FB02_7F80_0306_F9FC_0207_FF00_08F8, 2'd0, 1'b1, "R9 byte lanes");
        run({8{16'h8001}}, 128'h0105_FB02_7F80_0306_F9FC_0207_FF00_08F8, 2'd1, 1'b0, "R2 half lanes");

        // R10: output holds when idle.
        held = data_out;
        @(negedge clk);
        data_in = ~data_in; count_in = '0; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && data_out === held, "R10 hold", data_out, held);

        // Random mix over all sizes, modes and the full count byte range.
        for (int t = 0; t < 400; t++) begin
            d = {$urandom(), $urandom(), $urandom(), $urandom()};
            c = {$urandom(), $urandom(), $urandom(), $urandom()};
            run(d, c, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R3 R4 R5 R6 R7 R8 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule